// File: doc/BRIEF.md
# Serial Control Word Receiver

This block is the device-side end of a three-wire control port: an active-low chip-select, a serial clock and a data line. While chip-select is low, the block samples one data bit on each rising edge of the serial clock and shifts the word in least significant bit first. When chip-select rises after exactly sixteen clock edges, the word is written to a control register. That register drives the power switches, the path and filter selections, the two mute controls, a 5-bit volume code and the bias-mode flag of an audio front end. All three serial pins and the standby input are resynchronised to a fast system clock, and all edge detection runs in that clock domain.

Two events open a reset window: releasing standby, and a frame that clears the bias flag while bias mode is active. A window starts with a power-on interval of `POR_CYCLES` system clocks. The first complete frame after that interval is a dummy and is discarded. The next complete frame is applied. Throughout the window the register holds its default pattern. A low level on the standby input forces every control output to its default value at once, without waiting for a clock edge.

Top module: `serial_ctl_rx`

## Requirements
- R1: A frame that is accepted outside the reset window is applied at the rise of chip-select. Word bit k is the k-th data bit clocked in (LSB first). The field positions are: bit0 mute transistor (1 = on), bit1 reference charge (1 = on), bit2 mic power off, bit3 level-control power off, bit4 record select, bit5 8 kHz trap select, bit6 record amp off, bit7 line amp off, bit8 line mute, bit9 speaker off, bits 10..14 volume, bit15 bias.
- R2: The `volume` output carries word bits 10..14 with weights 1, 2, 4, 8 and 16. Code 0 is the minimum (muted) and code 31 is the maximum.
- R3: After system reset, and whenever the synchronised standby input is low, the control register holds the default word 16'h03EF. In that word bits 0, 1, 2, 3, 5, 6, 7, 8 and 9 are set and all other bits are clear.
- R4: While `standby_n` is low, every control output shows its default value in the same cycle. This holds even if a valid frame ends while standby is falling.
- R5: For `POR_CYCLES` system clocks after standby is released, the outputs stay at their defaults. A frame that ends inside this interval has no effect and does not count as the dummy frame.
- R6: After the power-on interval, the first accepted frame is discarded. The second accepted frame is applied.
- R7: A frame with any number of serial clock rising edges other than 16 is discarded. It does not change the outputs and is not counted as the dummy frame.
- R8: A valid frame that clears bit15 while bias mode is active returns the register to its defaults. It then starts a new power-on interval, a dummy frame and an applied frame, in that order.
- R9: A valid frame that sets bit15 is applied like any other frame, and `bias_mode` reads 1.
- R10: Serial clock and data activity while chip-select is high leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to sample the serial pins |
| rst_n | input | 1 | Asynchronous system reset, active low |
| standby_n | input | 1 | Standby control; low holds defaults, high releases the block |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, LSB first |
| mute_tr_on | output | 1 | Line mute transistor enable (word bit 0) |
| ref_charge_on | output | 1 | Reference charging switch (bit 1) |
| mic_pwr_off | output | 1 | Mic amp power off (bit 2) |
| alc_pwr_off | output | 1 | Level-control amp power off (bit 3) |
| rec_select | output | 1 | 1 = record path, 0 = playback (bit 4) |
| trap_8k | output | 1 | 1 = 8 kHz trap, 0 = 16 kHz (bit 5) |
| rec_amp_off | output | 1 | Record amp power off (bit 6) |
| line_amp_off | output | 1 | Line output power off (bit 7) |
| line_mute | output | 1 | Line mute switch (bit 8) |
| spk_pwr_off | output | 1 | Speaker amp power off (bit 9) |
| volume | output | 5 | Volume code, 0 = mute, 31 = maximum (bits 10..14) |
| bias_mode | output | 1 | Bias mode flag (bit 15) |

## Verification
Two functions can fall in the same system clock: the rising edge of chip-select that completes a valid frame, and the fall of standby. The bench provokes this by lowering `standby_n` on the same clock phase in which it raises `cs_n`, so that both reach the synchroniser together. A correct design lets standby win. The outputs show defaults at once, and after standby is released the full power-on, dummy and applied sequence is needed before any new word appears. A second collision occurs inside the sequencer, where a bias-cancel frame is both a completed frame and the opening of a reset window. The bench judges this case by checking that the cancel frame's payload never reaches the outputs.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int CW_BITS  = 16;
  localparam int VOL_W    = 5;
  localparam int VOL_POS  = 10;
  localparam int BIAS_POS = 15;

  localparam logic [CW_BITS-1:0] CW_DEFAULT = 16'h03EF;

  // Field layout, MSB first, so that a cast from the raw word lines up.
  typedef struct packed {
    logic             bias;
    logic [VOL_W-1:0] vol;
    logic             spk_off;
    logic             line_mute;
    logic             line_off;
    logic             rec_off;
    logic             trap8k;
    logic             rec_sel;
    logic             alc_off;
    logic             mic_off;
    logic             ref_chg;
    logic             mute_tr;
  } ctl_fields_t;

  typedef enum logic [1:0] {
    SEQ_PULSE = 2'd0,
    SEQ_DUMMY = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;

  // The newest bit enters at the top, so the first bit ends up at bit 0.
  function automatic logic [CW_BITS-1:0] shift_lsb_first(
      input logic [CW_BITS-1:0] sr, input logic bit_in);
    return {bit_in, sr[CW_BITS-1:1]};
  endfunction

  function automatic logic bias_of(input logic [CW_BITS-1:0] w);
    return w[BIAS_POS];
  endfunction

  function automatic logic is_bias_cancel(input logic cur_bias,
                                          input logic new_bias);
    return cur_bias & ~new_bias;
  endfunction

  function automatic ctl_fields_t split_fields(input logic [CW_BITS-1:0] w);
    return ctl_fields_t'(w);
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int           N    = 4,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] meta_q, sync_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= IDLE[i];
        sync_q[i] <= IDLE[i];
        prev_q[i] <= IDLE[i];
      end else begin
        meta_q[i] <= din[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
      end
    end
    assign lvl[i]  = sync_q[i];
    assign rise[i] = sync_q[i] & ~prev_q[i];
    assign fall[i] = ~sync_q[i] & prev_q[i];
  end

endmodule

// File: rtl/sctl_shift.sv
module sctl_shift
  import sctl_pkg::*;
#(
  parameter int W = CW_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_active,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         ck_rise,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         frame_end,
  output logic         frame_ok
);

  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(W + 1);

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take_bit;

  assign take_bit = cs_active & ck_rise & ~cs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
    end else if (take_bit) begin
      sr_q <= shift_lsb_first(sr_q, din);
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word      = sr_q;
  assign frame_end = cs_rise;
  assign frame_ok  = cs_rise & (cnt_q == CNT_FULL);

endmodule

// File: rtl/sctl_seq.sv
module sctl_seq
  import sctl_pkg::*;
#(
  parameter int POR_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_up,
  input  logic       frame_good,
  input  logic       cur_bias,
  input  logic       new_bias,
  output logic       apply,
  output logic       dummy_drop,
  output logic       bias_exit,
  output logic       in_window,
  output seq_state_t state
);

  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_CYCLES - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] por_cnt_q;
  logic             good;

  assign good       = stby_up & frame_good;
  assign dummy_drop = good & (state_q == SEQ_DUMMY);
  assign bias_exit  = good & (state_q == SEQ_RUN) & is_bias_cancel(cur_bias, new_bias);
  assign apply      = good & (state_q == SEQ_RUN) & ~is_bias_cancel(cur_bias, new_bias);
  assign in_window  = (state_q != SEQ_RUN);
  assign state      = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_PULSE;
      por_cnt_q <= '0;
    end else if (!stby_up) begin
      state_q   <= SEQ_PULSE;
      por_cnt_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_PULSE: begin
          if (por_cnt_q == CNT_LAST) begin
            state_q   <= SEQ_DUMMY;
            por_cnt_q <= '0;
          end else begin
            por_cnt_q <= por_cnt_q + 1'b1;
          end
        end
        SEQ_DUMMY: if (dummy_drop) state_q <= SEQ_RUN;
        SEQ_RUN: begin
          if (bias_exit) begin
            state_q   <= SEQ_PULSE;
            por_cnt_q <= '0;
          end
        end
        default: state_q <= SEQ_PULSE;
      endcase
    end
  end

endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx
  import sctl_pkg::*;
#(
  parameter int POR_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdata,
  output logic             mute_tr_on,
  output logic             ref_charge_on,
  output logic             mic_pwr_off,
  output logic             alc_pwr_off,
  output logic             rec_select,
  output logic             trap_8k,
  output logic             rec_amp_off,
  output logic             line_amp_off,
  output logic             line_mute,
  output logic             spk_pwr_off,
  output logic [VOL_W-1:0] volume,
  output logic             bias_mode
);

  localparam int SI_CS = 0;
  localparam int SI_CK = 1;
  localparam int SI_DT = 2;
  localparam int SI_SB = 3;
  localparam int SI_N  = 4;
  localparam logic [SI_N-1:0] SI_IDLE = 4'b0001;

  logic [SI_N-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {standby_n, sdata, sclk, cs_n};

  sctl_sync #(.N(SI_N), .IDLE(SI_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_raw),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  // Named events for the checker.
  logic cs_rise, cs_fall, ck_rise, stby_s;
  assign cs_rise = pin_rise[SI_CS];
  assign cs_fall = pin_fall[SI_CS];
  assign ck_rise = pin_rise[SI_CK];
  assign stby_s  = pin_lvl[SI_SB];

  logic unused_edges;
  assign unused_edges = &{1'b0, pin_fall[SI_CK], pin_rise[SI_DT], pin_fall[SI_DT],
                          pin_rise[SI_SB], pin_fall[SI_SB]};

  logic [CW_BITS-1:0] sr_word;
  logic               frame_end, frame_ok;

  sctl_shift #(.W(CW_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_active(~pin_lvl[SI_CS]),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .ck_rise  (ck_rise),
    .din      (pin_lvl[SI_DT]),
    .word     (sr_word),
    .frame_end(frame_end),
    .frame_ok (frame_ok)
  );

  logic [CW_BITS-1:0] word_q;
  logic               apply, dummy_drop, bias_exit, in_window;
  seq_state_t         seq_state;

  sctl_seq #(.POR_CYCLES(POR_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_up   (stby_s),
    .frame_good(frame_ok),
    .cur_bias  (bias_of(word_q)),
    .new_bias  (bias_of(sr_word)),
    .apply     (apply),
    .dummy_drop(dummy_drop),
    .bias_exit (bias_exit),
    .in_window (in_window),
    .state     (seq_state)
  );

  logic unused_state;
  assign unused_state = &{1'b0, seq_state};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   word_q <= CW_DEFAULT;
    else if (!stby_s || bias_exit) word_q <= CW_DEFAULT;
    else if (apply)               word_q <= sr_word;
  end

  // The raw standby pin overrides the register without waiting for a clock.
  logic [CW_BITS-1:0] out_word;
  ctl_fields_t        f;
  assign out_word = standby_n ? word_q : CW_DEFAULT;
  assign f        = split_fields(out_word);

  assign mute_tr_on    = f.mute_tr;
  assign ref_charge_on = f.ref_chg;
  assign mic_pwr_off   = f.mic_off;
  assign alc_pwr_off   = f.alc_off;
  assign rec_select    = f.rec_sel;
  assign trap_8k       = f.trap8k;
  assign rec_amp_off   = f.rec_off;
  assign line_amp_off  = f.line_off;
  assign line_mute     = f.line_mute;
  assign spk_pwr_off   = f.spk_off;
  assign volume        = f.vol;
  assign bias_mode     = f.bias;

endmodule

// File: rtl/sctl_checker.sv
module sctl_checker
  import sctl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               stby_s,
  input logic [CW_BITS-1:0] word_q,
  input logic [CW_BITS-1:0] sr_word,
  input logic               frame_end,
  input logic               frame_ok,
  input logic               apply,
  input logic               dummy_drop,
  input logic               bias_exit,
  input logic               in_window
);

  AST_STBY_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_s |=> word_q == CW_DEFAULT); // R3

  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> word_q == CW_DEFAULT); // R5

  AST_APPLY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && stby_s) |=> word_q == $past(sr_word)); // R1

  AST_BAD_FRAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |-> (!apply && !dummy_drop && !bias_exit)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({apply, dummy_drop, bias_exit})); // R6

  AST_BIAS_EXIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    bias_exit |=> (in_window && word_q == CW_DEFAULT)); // R8

  AST_NO_STRAY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_s && !apply && !bias_exit) |=> $stable(word_q)); // R10

endmodule

bind serial_ctl_rx sctl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stby_s    (stby_s),
  .word_q    (word_q),
  .sr_word   (sr_word),
  .frame_end (frame_end),
  .frame_ok  (frame_ok),
  .apply     (apply),
  .dummy_drop(dummy_drop),
  .bias_exit (bias_exit),
  .in_window (in_window)
);

// File: tb/tb_serial_ctl_rx.sv
module tb_serial_ctl_rx;

  localparam int POR = 400;
  localparam logic [15:0] DEF = 16'h03EF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic mute_tr_on, ref_charge_on, mic_pwr_off, alc_pwr_off, rec_select, trap_8k;
  logic rec_amp_off, line_amp_off, line_mute, spk_pwr_off, bias_mode;
  logic [4:0] volume;

  always #10 clk = ~clk;

  serial_ctl_rx #(.POR_CYCLES(POR)) dut (
    .clk(clk), .rst_n(rst_n), .standby_n(standby_n),
    .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .mute_tr_on(mute_tr_on), .ref_charge_on(ref_charge_on),
    .mic_pwr_off(mic_pwr_off), .alc_pwr_off(alc_pwr_off),
    .rec_select(rec_select), .trap_8k(trap_8k), .rec_amp_off(rec_amp_off),
    .line_amp_off(line_amp_off), .line_mute(line_mute), .spk_pwr_off(spk_pwr_off),
    .volume(volume), .bias_mode(bias_mode)
  );

  int checks = 0;
  int fails = 0;
  int wd = 0;
  bit done = 1'b0;

  function automatic logic [15:0] got_word();
    logic [15:0] w;
    w[0] = mute_tr_on;   w[1] = ref_charge_on; w[2] = mic_pwr_off;
    w[3] = alc_pwr_off;  w[4] = rec_select;    w[5] = trap_8k;
    w[6] = rec_amp_off;  w[7] = line_amp_off;  w[8] = line_mute;
    w[9] = spk_pwr_off;
    for (int k = 0; k < 5; k++) w[10 + k] = volume[k];
    w[15] = bias_mode;
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits, input bit drop_stby);
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[i] : 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    if (drop_stby) standby_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] last;
    logic [15:0] w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 reset defaults", got_word(), DEF);
    check("R4 standby low", got_word(), DEF);

    // Release standby; a frame ending inside the pulse is ignored (R5).
    standby_n = 1'b1;
    repeat (50) @(negedge clk);
    check("R5 early pulse", got_word(), DEF);
    send_frame(16'h1234, 16, 1'b0);
    check("R5 frame in pulse", got_word(), DEF);
    repeat (POR) @(negedge clk);
    send_frame(16'h5555, 15, 1'b0);
    check("R7 short frame not dummy", got_word(), DEF);
    send_frame(16'h2BCD, 16, 1'b0);
    check("R6 dummy dropped", got_word(), DEF);
    send_frame(16'h1C10, 16, 1'b0);
    check("R6 second frame applied", got_word(), 16'h1C10);

    // R1: each single-bit field toggled from the default pattern.
    for (int b = 0; b < 10; b++) begin
      w = DEF ^ (16'h0001 << b);
      send_frame(w, 16, 1'b0);
      check("R1 field map", got_word(), w);
    end

    // R2: full volume sweep, expected code computed arithmetically.
    for (int v = 0; v < 32; v++) begin
      w = 16'((v * 1024) + 16'h0155);
      send_frame(w, 16, 1'b0);
      check("R2 volume", {11'd0, volume}, 16'(v));
      check("R2 word", got_word(), w);
    end
    last = w;

    // R7: all bad lengths 0..20 except 16.
    for (int n = 0; n <= 20; n++) begin
      if (n != 16) begin
        send_frame(16'h4A3C, n, 1'b0);
        check("R7 bad length", got_word(), last);
      end
    end

    // R10: activity with chip-select high.
    for (int i = 0; i < 20; i++) begin
      sdata = i[0];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    check("R10 idle clocks", got_word(), last);
    send_frame(16'h3C3C, 16, 1'b0);
    check("R10 next frame clean", got_word(), 16'h3C3C);

    // R9: entering bias mode.
    send_frame(16'h8123, 16, 1'b0);
    check("R9 bias applied", got_word(), 16'h8123);

    // R8: cancelling bias re-enters the sequence.
    send_frame(16'h1400, 16, 1'b0);
    check("R8 cancel gives defaults", got_word(), DEF);
    send_frame(16'h0F00, 16, 1'b0);
    check("R8 frame in pulse", got_word(), DEF);
    repeat (POR) @(negedge clk);
    send_frame(16'h2222, 16, 1'b0);
    check("R8 dummy dropped", got_word(), DEF);
    send_frame(16'h0A5A, 16, 1'b0);
    check("R8 applied after dummy", got_word(), 16'h0A5A);

    // R4: immediate forcing, before any clock edge.
    @(negedge clk) standby_n = 1'b0;
    #1 check("R4 immediate force", got_word(), DEF);
    repeat (6) @(negedge clk);
    standby_n = 1'b1;
    repeat (POR + 10) @(negedge clk);
    send_frame(16'h6666, 16, 1'b0);
    send_frame(16'h0F0F, 16, 1'b0);
    check("R6 after standby cycle", got_word(), 16'h0F0F);

    // R4 collision: standby falls with the closing chip-select edge.
    send_frame(16'h1111, 16, 1'b1);
    check("R4 collision forced", got_word(), DEF);
    standby_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R4 collision not applied", got_word(), DEF);
    repeat (POR) @(negedge clk);
    send_frame(16'h3333, 16, 1'b0);
    check("R4 collision dummy", got_word(), DEF);
    send_frame(16'h00F0, 16, 1'b0);
    check("R4 collision recovery", got_word(), 16'h00F0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule